// File: doc/BRIEF.md
# Master serial result transmitter

This block sends a converter's 16-bit result to a host over a three-wire serial link, and it generates the link's clock itself. A one-cycle `done_i` pulse marks a new result on `result_i`. The block then sends a framed burst of exactly sixteen clock pulses on `sclk_o`, with the data MSB first on `sdout_o`. A frame signal, `sync_o`, is asserted for the whole burst.

The serial clock is made by dividing the system clock by `DIV`, and each bit cell lasts `DIV` system cycles. The clock sits low for the first quarter of a cell, is high for the middle half, and is low again for the last quarter. Data changes only at a cell boundary, which falls in the middle of a low stretch, so the host can sample on either edge of the serial clock. Separate inputs invert the clock and the frame signal. A mode input chooses between two timings:
- The result is sent as soon as the conversion ends.
- The result is held and sent while the next conversion is running, shown by `busy_i` high.

The transmitter works only when the serial interface is selected and the internal clock source is chosen. A result that arrives during a frame is stored and sent after that frame ends.

Top module: `sertx_master`

## Requirements
- R1: A `done_i` pulse is ignored unless `ser_mode_i` = 1 and `ext_clk_i` = 0. While the block is not enabled in this way, no frame starts and `sync_o` stays at its inactive level.
- R2: A frame holds exactly 16 serial clock pulses, one per bit cell of `DIV` system cycles. Before inversion, `sclk_o` is high in cell phases `DIV/4` to `3*DIV/4-1` and low at all other times, including idle.
- R3: `sdout_o` carries result bit 15−n during bit cell n, so the MSB goes first. It changes only at cell boundaries, never at a serial clock edge, and it is 0 when idle.
- R4: Before inversion, `sync_o` is high (active high) for exactly 16·`DIV` consecutive cycles, covering every bit of the frame, and low otherwise.
- R5: `inv_sclk_i` = 1 inverts `sclk_o` and `inv_sync_i` = 1 inverts `sync_o`. Both inversions apply at all times, including idle.
- R6: With `rd_during_i` = 0, the first cycle of the frame (frame signal active, cell 0) starts at the second rising clock edge after the cycle in which `done_i` is sampled high.
- R7: With `rd_during_i` = 1, a stored result starts its frame only on the clock edge after `busy_i` is sampled high. While `busy_i` is low, the result is kept and not sent.
- R8: A result arriving during a frame is stored and sent in a later frame. There is at least one idle cycle between the two frames. If several results arrive before a frame starts, the most recent one is sent.
- R9: While `rst_n` is low, the outputs are inactive: `sdout_o` is 0 and `sclk_o` and `sync_o` equal their inversion inputs. Reset also clears any stored result, even one mid-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| result_i | input | WORD_W | Conversion result, valid with `done_i` |
| done_i | input | 1 | One-cycle pulse when a conversion ends |
| busy_i | input | 1 | High while a conversion is running |
| ser_mode_i | input | 1 | 1 selects the serial interface |
| ext_clk_i | input | 1 | 1 selects an external serial clock (transmitter idle) |
| inv_sclk_i | input | 1 | Inverts the serial clock output |
| inv_sync_i | input | 1 | Inverts the frame output |
| rd_during_i | input | 1 | 1 sends the held result during the next conversion |
| sclk_o | output | 1 | Generated serial clock |
| sync_o | output | 1 | Frame signal, active during the 16 bits |
| sdout_o | output | 1 | Serial data, MSB first |

## Verification
The bench sends a second and a third result in the middle of a frame. A design that drops the stored result, or that cuts the running frame short, would show a missing frame or a wrong word. It also sends a result in read-during-convert mode while `busy_i` stays low for a long time; a design that ignores the busy gate would start the frame too early. Pulses of `done_i` with serial mode off or with an external clock selected catch a design that decodes the enable wrongly, and a reset in the middle of a frame catches stored state that survives reset. Every frame is decoded at the serial clock's rising edges and compared against the word sent, with a count of its pulse and frame lengths. This exposes an off-by-one cell count, bit order reversed, or data that changes at a clock edge.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/sertx_rst_sync.sv
module sertx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/sertx_clkgen.sv
module sertx_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk_raw,
  output logic cell_end
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(DIV / 4);
  localparam logic [PH_W-1:0] PH_FALL = PH_W'((3 * DIV) / 4);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;

  always_comb begin
    phase_d = phase_q;
    if (!run) begin
      phase_d = '0;
    end else if (phase_q == PH_LAST) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign sclk_raw = run && (phase_q >= PH_RISE) && (phase_q < PH_FALL);
  assign cell_end = run && (phase_q == PH_LAST);
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              done,
  input  logic [WORD_W-1:0] result,
  input  logic              busy,
  input  logic              rd_during,
  input  logic              cell_end,
  output logic              frame_active,
  output logic              load,
  output logic [WORD_W-1:0] load_word,
  output logic              pending
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  tx_state_e         state_q, state_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              pend_q, pend_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              capture;
  logic              start;
  logic              last_cell;

  assign capture   = done && enable;
  assign start     = (state_q == ST_IDLE) && pend_q && enable && (!rd_during || busy);
  assign last_cell = (state_q == ST_SEND) && cell_end && (bit_q == BIT_LAST);

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    pend_d  = pend_q;
    hold_d  = hold_q;
    if (start) begin
      state_d = ST_SEND;
      bit_d   = '0;
      pend_d  = 1'b0;
    end else if (last_cell) begin
      state_d = ST_IDLE;
      bit_d   = '0;
    end else if (cell_end) begin
      bit_d   = bit_q + 1'b1;
    end
    if (capture) begin
      pend_d = 1'b1;
      hold_d = result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      pend_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      pend_q  <= pend_d;
      hold_q  <= hold_d;
    end
  end

  assign frame_active = (state_q == ST_SEND);
  assign load         = start;
  assign load_word    = hold_q;
  assign pending      = pend_q;
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              advance,
  output logic              msb
);
  logic [WORD_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = load_word;
    end else if (advance) begin
      sh_d = {sh_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign msb = sh_q[WORD_W-1];
endmodule

// File: rtl/sertx_master.sv
module sertx_master #(
  parameter int WORD_W = 16,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] result_i,
  input  logic              done_i,
  input  logic              busy_i,
  input  logic              ser_mode_i,
  input  logic              ext_clk_i,
  input  logic              inv_sclk_i,
  input  logic              inv_sync_i,
  input  logic              rd_during_i,
  output logic              sclk_o,
  output logic              sync_o,
  output logic              sdout_o
);
  logic              rst_sync_n;
  logic              enable;
  logic              frame_active;
  logic              load;
  logic [WORD_W-1:0] load_word;
  logic              pending;
  logic              cell_end;
  logic              sclk_raw;
  logic              shift_msb;
  logic              sdout_raw;

  assign enable = ser_mode_i && !ext_clk_i;

  sertx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sertx_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .enable       (enable),
    .done         (done_i),
    .result       (result_i),
    .busy         (busy_i),
    .rd_during    (rd_during_i),
    .cell_end     (cell_end),
    .frame_active (frame_active),
    .load         (load),
    .load_word    (load_word),
    .pending      (pending)
  );

  sertx_clkgen #(.DIV(DIV)) u_clk (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (frame_active),
    .sclk_raw (sclk_raw),
    .cell_end (cell_end)
  );

  sertx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .load_word (load_word),
    .advance   (cell_end),
    .msb       (shift_msb)
  );

  assign sdout_raw = frame_active && shift_msb;
  assign sclk_o    = sclk_raw ^ inv_sclk_i;
  assign sync_o    = frame_active ^ inv_sync_i;
  assign sdout_o   = sdout_raw;
endmodule

// File: rtl/sertx_master_chk.sv
module sertx_master_chk #(
  parameter int WORD_W = 16,
  parameter int DIV    = 4
) (
  input logic clk,
  input logic rst_sync_n,
  input logic enable,
  input logic done_i,
  input logic busy_i,
  input logic rd_during_i,
  input logic frame_active,
  input logic pending,
  input logic sclk_raw,
  input logic sdout_raw
);
  localparam int FRAME_CYC = WORD_W * DIV;

  logic [31:0] act_cnt;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      act_cnt <= '0;
    end else if (frame_active) begin
      act_cnt <= act_cnt + 1;
    end else begin
      act_cnt <= '0;
    end
  end

  a_r1_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!enable && !frame_active) |=> !frame_active);

  a_r2_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !frame_active |-> !sclk_raw);

  a_r3_data_steady_at_edges: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(sclk_raw) || $fell(sclk_raw)) |-> $stable(sdout_raw));

  a_r4_frame_length: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(frame_active) |-> (act_cnt == FRAME_CYC));

  a_r7_start_needs_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(frame_active) && $past(rd_during_i)) |-> $past(busy_i));

  a_r8_result_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_i && enable) |=> pending);
endmodule

bind sertx_master sertx_master_chk #(.WORD_W(WORD_W), .DIV(DIV)) chk_i (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .enable       (enable),
  .done_i       (done_i),
  .busy_i       (busy_i),
  .rd_during_i  (rd_during_i),
  .frame_active (frame_active),
  .pending      (pending),
  .sclk_raw     (sclk_raw),
  .sdout_raw    (sdout_raw)
);

// File: tb/sertx_master_tb_top.sv
`timescale 1ns/1ps
module sertx_master_tb_top;
  localparam int WORD_W = 16;
  localparam int DIV    = 4;
  localparam int FRAME  = WORD_W * DIV;

  logic clk;
  logic rst_n;
  logic [WORD_W-1:0] result_i;
  logic done_i, busy_i, ser_mode_i, ext_clk_i;
  logic inv_sclk_i, inv_sync_i, rd_during_i;
  logic sclk_o, sync_o, sdout_o;

  int checks;
  int fails;
  string cur_req;
  bit finished;

  sertx_master #(.WORD_W(WORD_W), .DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .result_i(result_i), .done_i(done_i),
    .busy_i(busy_i), .ser_mode_i(ser_mode_i), .ext_clk_i(ext_clk_i),
    .inv_sclk_i(inv_sclk_i), .inv_sync_i(inv_sync_i), .rd_during_i(rd_during_i),
    .sclk_o(sclk_o), .sync_o(sync_o), .sdout_o(sdout_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference
  bit          m_act;
  int          m_k;
  bit          m_pend;
  logic [15:0] m_pdata;
  logic [15:0] m_word;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_k = 0; m_pend = 0; m_pdata = '0; m_word = '0;
    end else begin
      bit en;
      en = ser_mode_i && !ext_clk_i;
      if (m_act) begin
        if (m_k == FRAME - 1) m_act = 0;
        else m_k = m_k + 1;
      end else if (m_pend && en && (!rd_during_i || busy_i)) begin
        m_act = 1; m_k = 0; m_word = m_pdata; m_pend = 0;
      end
      if (done_i && en) begin
        m_pdata = result_i; m_pend = 1;
      end
    end
  end

  // monitor state
  bit          prev_sclk;
  bit          prev_sync;
  int          mon_bits;
  int          mon_len;
  logic [15:0] mon_word;
  int          frames_seen;
  logic [15:0] last_word;

  task automatic check1(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      int ph, bn;
      logic e_sclk, e_sync, e_sd;
      bit raw_s, raw_y;
      ph = m_k % DIV;
      bn = m_k / DIV;
      e_sync = m_act ^ inv_sync_i;
      e_sclk = (m_act && ph >= DIV / 4 && ph < (3 * DIV) / 4) ^ inv_sclk_i;
      e_sd   = m_act ? m_word[15 - bn] : 1'b0;
      checks++;
      if (sclk_o !== e_sclk || sync_o !== e_sync || sdout_o !== e_sd) begin
        fails++;
        $display("FAIL %s sclk/sync/sdout act=%0b%0b%0b exp=%0b%0b%0b t=%0t",
                 cur_req, sclk_o, sync_o, sdout_o, e_sclk, e_sync, e_sd, $time);
      end
      raw_s = sclk_o ^ inv_sclk_i;
      raw_y = sync_o ^ inv_sync_i;
      if (!rst_n) begin
        mon_bits = 0; mon_len = 0; mon_word = '0;
      end else begin
        if (raw_y) mon_len++;
        if (raw_y && raw_s && !prev_sclk) begin
          mon_word = {mon_word[14:0], sdout_o};
          mon_bits++;
        end
        if (!raw_y && prev_sync) begin
          check_int("R2", "pulses per frame", mon_bits, WORD_W);
          check_int("R4", "frame length", mon_len, FRAME);
          check_int("R3", "decoded word", int'(mon_word), int'(m_word));
          frames_seen++;
          last_word = mon_word;
          mon_bits = 0; mon_len = 0; mon_word = '0;
        end
      end
      prev_sclk = raw_s;
      prev_sync = raw_y;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_done(input logic [15:0] w);
    result_i = w; done_i = 1'b1;
    tick(1);
    done_i = 1'b0;
  endtask

  task automatic finish_run;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    $display("FAIL watchdog expired");
    fails++;
    finish_run();
  end

  initial begin
    int f0;
    checks = 0; fails = 0; finished = 0; frames_seen = 0;
    prev_sclk = 0; prev_sync = 0;
    cur_req = "R9";
    rst_n = 0; result_i = '0; done_i = 0; busy_i = 0; ser_mode_i = 1;
    ext_clk_i = 0; inv_sclk_i = 0; inv_sync_i = 0; rd_during_i = 0;
    tick(4);
    check1("reset sdout", sdout_o, 1'b0);
    check1("reset sync", sync_o, 1'b0);
    rst_n = 1;
    tick(6);

    // R1: disabled configurations ignore done
    cur_req = "R1";
    f0 = frames_seen;
    ser_mode_i = 0;
    pulse_done(16'h1234);
    tick(10);
    ser_mode_i = 1; ext_clk_i = 1;
    pulse_done(16'h4321);
    tick(10);
    ext_clk_i = 0;
    tick(80);
    check_int("R1", "frames while disabled", frames_seen, f0);
    check1("sync idle", sync_o, 1'b0);

    // R6/R2/R3/R4: send after conversion
    cur_req = "R6";
    pulse_done(16'hA5C3);
    check1("sync before start", sync_o, 1'b0);
    tick(1);
    check1("sync at start", sync_o, 1'b1);
    tick(FRAME + 5);
    pulse_done(16'h8001);
    tick(FRAME + 5);
    pulse_done(16'h7FFE);
    tick(FRAME + 5);
    check_int("R3", "last word", int'(last_word), 16'h7FFE);

    // R5: inversions, idle and in frame
    cur_req = "R5";
    inv_sclk_i = 1; tick(3);
    inv_sync_i = 1; tick(3);
    check1("idle sclk inverted", sclk_o, 1'b1);
    check1("idle sync inverted", sync_o, 1'b1);
    pulse_done(16'h3C96);
    tick(FRAME + 5);
    inv_sclk_i = 0; inv_sync_i = 0;
    tick(3);

    // R8: results arriving mid-frame
    cur_req = "R8";
    f0 = frames_seen;
    pulse_done(16'hF00F);
    tick(20);
    pulse_done(16'h0FF0);
    tick(15);
    pulse_done(16'hBEEF);
    tick(2 * FRAME + 10);
    check_int("R8", "frames for mid-frame results", frames_seen - f0, 2);
    check_int("R8", "newest stored word sent", int'(last_word), 16'hBEEF);

    // R7: read during the next conversion
    cur_req = "R7";
    rd_during_i = 1; busy_i = 0;
    f0 = frames_seen;
    pulse_done(16'hC001);
    tick(40);
    check_int("R7", "no frame while not busy", frames_seen, f0);
    check1("sync held off", sync_o, 1'b0);
    busy_i = 1;
    tick(1);
    check1("sync after busy", sync_o, 1'b1);
    tick(FRAME + 5);
    busy_i = 0;
    check_int("R7", "frame during busy", frames_seen - f0, 1);
    busy_i = 1;
    pulse_done(16'h5AA5);
    tick(FRAME + 5);
    busy_i = 0;
    rd_during_i = 0;
    tick(4);

    // R9: reset mid-frame clears everything
    cur_req = "R9";
    pulse_done(16'h1357);
    tick(10);
    pulse_done(16'h2468);
    tick(5);
    rst_n = 0;
    tick(3);
    check1("reset mid-frame sync", sync_o, 1'b0);
    rst_n = 1;
    f0 = frames_seen;
    tick(FRAME * 2);
    check_int("R9", "stored word discarded", frames_seen, f0);
    finish_run();
  end
endmodule